// File: doc/BRIEF.md
# Dual-CPU Address Region Decoder

This block sits between one processor of a two-processor cluster and the memories and register blocks that the processor can reach. Every request is sorted by address bits 31..29 together with the two chip-select bits 26..25 into one of 32 region slots. Mapped requests go out as a single registered target beat that carries a target code and the offset, masked to the width of that target. The same module is placed once per processor. A one-bit identity input steers requests for the private boot ROM and the private on-chip data array to the copy that belongs to that processor.

Chip-select 0 is decoded a second time on address bits 17..8. This gives the system registers, the video registers and the palette, with a private boot ROM in the lowest addresses. Bit 29 only mirrors the low slots. A 32-bit request to a 16-bit target is issued as two halfword beats, high half first, and the results are joined together. The peripheral slot takes 32-bit requests in a single beat. Byte reads from 16-bit targets select one byte lane by the low address bit. Requests that hit no target produce no beat. They complete with zero data and a fault flag.

The processor holds a request until the decoder answers with a one-cycle ready pulse.

Top module: `cpu_region_decoder`

## Requirements
- R1: While reset is held and in the first idle cycles after it, tgt_valid and cpu_ready are low, cpu_rdata is zero and cpu_fault is low.
- R2: The slot is {A31,A30,A29,A26,A25}. Slots 0/4 are chip-select 0, slots 1/5 are cartridge ROM, slots 2/6 are frame buffer and slots 3/7 are SDRAM, so A29 only mirrors. Slot 0x18 is the data array and slot 0x1F is the peripheral space. Every other slot is unmapped.
- R3: In chip-select 0, bits 17..8 equal to 0x040 select the system registers (code 1) and 0x041 select the video registers (code 2). Both use offset bits 7..0.
- R4: Palette (code 3, offset bits 8..0) is read when bits 17..8 equal 0x042 and is written when bits 17..9 equal 0x021. A read at 0x043xx is therefore unmapped.
- R5: A chip-select 0 read whose full address is below BOOT_BYTES, after the register decodes, selects boot ROM code 4 for cpu_id 0 and code 5 for cpu_id 1, with the offset masked to BOOT_BYTES-1. Boot ROM writes are unmapped.
- R6: Cartridge ROM (code 6) is read-only, with offset mask 0x3FFFFF. Frame buffer (code 7) uses mask 0x1FFFF and SDRAM (code 8) uses mask 0x3FFFF, both for reads and writes.
- R7: Slot 0x18 selects data array code 9 for cpu_id 0 and code 10 for cpu_id 1, with offset bits 11..0. Slot 0x1F selects peripheral code 11 with offset bits 8..0 and passes the request size through unchanged.
- R8: Size codes are 0 byte, 1 halfword and 2 word. A word request outside slot 0x1F becomes two size-1 beats: the address with bit 1 clear carrying write bits 31..16, then bit 1 set carrying bits 15..0. Read data is {first[15:0], second[15:0]}.
- R9: A byte read from a non-peripheral target returns tgt_rdata[15:8] for an even address and tgt_rdata[7:0] for an odd one, zero-extended. Peripheral byte and halfword reads return the low 8 or 16 bits.
- R10: An unmapped request raises no tgt_valid. It completes with cpu_rdata zero and cpu_fault high for the single ready cycle.
- R11: The first target beat is valid in the cycle after the request is sampled. cpu_ready rises in the cycle after the last beat, or after the unmapped slot, and lasts one cycle. Outside the ready cycle, cpu_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_id | input | 1 | Which processor this instance serves (0 or 1) |
| req_valid | input | 1 | Request held until cpu_ready |
| req_write | input | 1 | 1 for a write |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data, right-aligned |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with cpu_ready |
| cpu_fault | output | 1 | Request hit no target |
| tgt_valid | output | 1 | A target beat is presented |
| tgt_sel | output | 4 | Target code of the beat |
| tgt_write | output | 1 | Beat is a write |
| tgt_size | output | 2 | Beat size code |
| tgt_offset | output | 22 | Masked offset within the target |
| tgt_wdata | output | 32 | Beat write data, right-aligned |
| tgt_rdata | input | 32 | Data returned by the selected target during the beat |

## Verification
The bench targets the palette read/write window mismatch. A decoder that used one window for both would route a read at 0x43xx to the palette when it should fault, or drop a write that it should accept. It also tests the boot ROM edge at exactly BOOT_BYTES and the A29 mirror above it, where a missing full-address comparison would let a mirrored low address reach the boot ROM. Word requests are sent to SDRAM, to the system registers and to an unmapped slot, and a peripheral word is sent as well. Swapped halves, a wrong second address, or a split of the peripheral beat all show up as a wrong beat sequence or wrong joined data. Byte reads at even and odd addresses catch a reversed lane choice.

// File: rtl/cpu_region_decoder.sv
module cpu_region_decoder #(
  parameter int BOOT_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_id,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        cpu_fault,
  output logic        tgt_valid,
  output logic [3:0]  tgt_sel,
  output logic        tgt_write,
  output logic [1:0]  tgt_size,
  output logic [21:0] tgt_offset,
  output logic [31:0] tgt_wdata,
  input  logic [31:0] tgt_rdata
);
  localparam logic [3:0] SEL_NONE = 4'd0, SEL_SYS = 4'd1, SEL_VID = 4'd2, SEL_PAL = 4'd3,
                         SEL_BOOT0 = 4'd4, SEL_BOOT1 = 4'd5, SEL_CART = 4'd6, SEL_FB = 4'd7,
                         SEL_SDR = 4'd8, SEL_DA0 = 4'd9, SEL_DA1 = 4'd10, SEL_PERI = 4'd11;
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_BEAT1 = 2'd1, ST_BEAT2 = 2'd2, ST_RESP = 2'd3;
  localparam logic [21:0] BOOT_MASK = 22'(BOOT_BYTES - 1);
  localparam logic [4:0] SLOT_DA = 5'h18, SLOT_PERI = 5'h1F;

  logic [1:0]  state;
  logic [31:0] h_addr;
  logic [15:0] h_wlo;
  logic        h_wr, h_split, h_periph, h_err;
  logic [1:0]  h_size;
  logic [31:0] acc;

  logic [31:0] d_addr;
  logic        d_wr;
  logic [4:0]  d_slot;
  logic [9:0]  d_sub;
  logic [3:0]  d_sel;
  logic [21:0] d_off;

  assign d_addr = (state == ST_IDLE) ? req_addr : (h_addr | 32'h2);
  assign d_wr   = (state == ST_IDLE) ? req_write : h_wr;
  assign d_slot = {d_addr[31:29], d_addr[26:25]};
  assign d_sub  = d_addr[17:8];

  always_comb begin
    d_sel = SEL_NONE;
    d_off = '0;
    if (d_slot[4:3] == 2'b00) begin
      case (d_slot[1:0])
        2'd0: begin
          if (d_sub == 10'h040) begin
            d_sel = SEL_SYS;  d_off = {14'd0, d_addr[7:0]};
          end else if (d_sub == 10'h041) begin
            d_sel = SEL_VID;  d_off = {14'd0, d_addr[7:0]};
          end else if (!d_wr && d_addr < 32'(BOOT_BYTES)) begin
            d_sel = cpu_id ? SEL_BOOT1 : SEL_BOOT0;
            d_off = d_addr[21:0] & BOOT_MASK;
          end else if (d_wr ? (d_addr[17:9] == 9'h021) : (d_sub == 10'h042)) begin
            d_sel = SEL_PAL;  d_off = {13'd0, d_addr[8:0]};
          end
        end
        2'd1: if (!d_wr) begin
          d_sel = SEL_CART; d_off = d_addr[21:0];
        end
        2'd2: begin d_sel = SEL_FB;  d_off = {5'd0, d_addr[16:0]}; end
        default: begin d_sel = SEL_SDR; d_off = {4'd0, d_addr[17:0]}; end
      endcase
    end else if (d_slot == SLOT_DA) begin
      d_sel = cpu_id ? SEL_DA1 : SEL_DA0;
      d_off = {10'd0, d_addr[11:0]};
    end else if (d_slot == SLOT_PERI) begin
      d_sel = SEL_PERI;
      d_off = {13'd0, d_addr[8:0]};
    end
  end

  logic        split_in;
  logic [31:0] lane, beat_data;
  assign split_in = (req_size == SZ_W) && (d_slot != SLOT_PERI);
  assign lane     = (tgt_valid && !tgt_write) ? tgt_rdata : '0;

  always_comb begin
    if (h_periph)
      case (h_size)
        SZ_B:    beat_data = {24'd0, lane[7:0]};
        SZ_H:    beat_data = {16'd0, lane[15:0]};
        default: beat_data = lane;
      endcase
    else if (h_size == SZ_B)
      beat_data = {24'd0, h_addr[0] ? lane[7:0] : lane[15:8]};
    else
      beat_data = {16'd0, lane[15:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      h_addr <= '0; h_wlo <= '0; h_wr <= 1'b0; h_size <= SZ_B;
      h_split <= 1'b0; h_periph <= 1'b0; h_err <= 1'b0;
      acc <= '0;
      tgt_valid <= 1'b0; tgt_sel <= SEL_NONE; tgt_write <= 1'b0;
      tgt_size <= SZ_B; tgt_offset <= '0; tgt_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          h_addr <= req_addr; h_wlo <= req_wdata[15:0]; h_wr <= req_write;
          h_size <= req_size; h_split <= split_in;
          h_periph <= (d_slot == SLOT_PERI);
          h_err <= (d_sel == SEL_NONE);
          acc <= '0;
          tgt_valid <= (d_sel != SEL_NONE);
          tgt_sel <= d_sel;
          tgt_write <= req_write;
          tgt_size <= split_in ? SZ_H : req_size;
          tgt_offset <= d_off;
          if (split_in)            tgt_wdata <= {16'd0, req_wdata[31:16]};
          else if (req_size == SZ_B) tgt_wdata <= {24'd0, req_wdata[7:0]};
          else if (req_size == SZ_H) tgt_wdata <= {16'd0, req_wdata[15:0]};
          else                     tgt_wdata <= req_wdata;
          state <= ST_BEAT1;
        end
        ST_BEAT1: begin
          if (h_split) begin
            acc[31:16] <= lane[15:0];
            tgt_valid <= (d_sel != SEL_NONE);
            tgt_sel <= d_sel;
            tgt_offset <= d_off;
            tgt_wdata <= {16'd0, h_wlo};
            h_err <= h_err | (d_sel == SEL_NONE);
            state <= ST_BEAT2;
          end else begin
            acc <= beat_data;
            tgt_valid <= 1'b0;
            state <= ST_RESP;
          end
        end
        ST_BEAT2: begin
          acc[15:0] <= lane[15:0];
          tgt_valid <= 1'b0;
          state <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = (state == ST_RESP);
  assign cpu_rdata = cpu_ready ? acc : '0;
  assign cpu_fault = cpu_ready && h_err;
endmodule

module cpu_region_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tgt_valid,
  input logic [3:0]  tgt_sel,
  input logic        tgt_write,
  input logic [1:0]  tgt_size,
  input logic [21:0] tgt_offset,
  input logic        cpu_ready,
  input logic [31:0] cpu_rdata,
  input logic        cpu_fault
);
  // R11
  beat_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> !cpu_ready);
  // R11
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  // R10
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fault |-> (cpu_ready && cpu_rdata == 32'd0));
  // R8
  word_only_peri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_sel != 4'd11) |-> (tgt_size != 2'd2));
  // R5
  boot_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && (tgt_sel == 4'd4 || tgt_sel == 4'd5)) |-> !tgt_write);
  // R6
  cart_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_sel == 4'd6) |-> !tgt_write);
  // R4
  pal_read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_sel == 4'd3 && !tgt_write) |-> !tgt_offset[8]);
  // R6
  fb_offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_sel == 4'd7) |-> (tgt_offset <= 22'h1FFFF));
  // R3
  reg_offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && (tgt_sel == 4'd1 || tgt_sel == 4'd2)) |-> (tgt_offset[21:8] == 14'd0));
endmodule

bind cpu_region_decoder cpu_region_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_valid(tgt_valid), .tgt_sel(tgt_sel),
  .tgt_write(tgt_write), .tgt_size(tgt_size), .tgt_offset(tgt_offset),
  .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_fault(cpu_fault)
);

// File: tb/cpu_region_decoder_tb.sv
module cpu_region_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_id = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        cpu_ready, cpu_fault, tgt_valid, tgt_write;
  logic [31:0] cpu_rdata, tgt_wdata, tgt_rdata;
  logic [3:0]  tgt_sel;
  logic [1:0]  tgt_size;
  logic [21:0] tgt_offset;

  always #5 clk = ~clk;

  cpu_region_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .req_valid(req_valid),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .cpu_fault(cpu_fault), .tgt_valid(tgt_valid), .tgt_sel(tgt_sel),
    .tgt_write(tgt_write), .tgt_size(tgt_size), .tgt_offset(tgt_offset),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
  );

  // target model: tag word built from the beat it answers
  assign tgt_rdata = {4'hC, tgt_sel, 2'b00, tgt_offset};

  typedef struct {
    bit        tv;
    bit [3:0]  sel;
    bit [21:0] off;
    bit        wr;
    bit [1:0]  sz;
    bit [31:0] wd;
    bit        rdy;
    bit [31:0] rd;
    bit        flt;
    string     tag;
  } rec_t;

  rec_t exp_q[$];
  rec_t cur;
  int n_cmp = 0, n_bad = 0;

  function automatic void model_dec(input logic [31:0] a, input bit wr, input bit id,
                                    output logic [3:0] s, output logic [21:0] o);
    int unsigned slot, page;
    slot = ((a >> 25) & 32'h3) | ((a >> 27) & 32'h1c);
    page = (a >> 8) & 32'h3ff;
    s = 4'd0; o = '0;
    if (slot == 0 || slot == 4) begin
      if (page == 'h40) begin s = 4'd1; o = 22'(a & 32'hff); end
      else if (page == 'h41) begin s = 4'd2; o = 22'(a & 32'hff); end
      else if (!wr && a < 32'd2048) begin s = id ? 4'd5 : 4'd4; o = 22'(a & 32'h7ff); end
      else if ((!wr && page == 'h42) || (wr && (page == 'h42 || page == 'h43))) begin
        s = 4'd3; o = 22'(a & 32'h1ff);
      end
    end else if (slot == 1 || slot == 5) begin
      if (!wr) begin s = 4'd6; o = 22'(a & 32'h3fffff); end
    end else if (slot == 2 || slot == 6) begin s = 4'd7; o = 22'(a & 32'h1ffff); end
    else if (slot == 3 || slot == 7) begin s = 4'd8; o = 22'(a & 32'h3ffff); end
    else if (slot == 'h18) begin s = id ? 4'd10 : 4'd9; o = 22'(a & 32'hfff); end
    else if (slot == 'h1f) begin s = 4'd11; o = 22'(a & 32'h1ff); end
  endfunction

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input string tag);
    rec_t r, idle, resp;
    rec_t beats[$];
    logic [3:0] s; logic [21:0] o;
    logic [31:0] full, acc;
    bit peri, split, flt;
    peri = (((a >> 25) & 32'h3) | ((a >> 27) & 32'h1c)) == 32'h1f;
    split = (sz == 2'd2) && !peri;
    acc = 0; flt = 0;
    idle = '{default: 0, tag: tag};
    if (split) begin
      for (int h = 0; h < 2; h++) begin
        model_dec(h ? (a + 32'd2) : a, wr, cpu_id, s, o);
        r = '{default: 0, tag: tag};
        r.tv = (s != 0); r.sel = s; r.off = o; r.wr = wr; r.sz = 2'd1;
        r.wd = h ? (wd & 32'hffff) : (wd >> 16);
        if (s == 0) flt = 1;
        else if (!wr) acc = h ? (acc | {16'd0, o[15:0]}) : {o[15:0], 16'd0};
        beats.push_back(r);
      end
    end else begin
      model_dec(a, wr, cpu_id, s, o);
      r = '{default: 0, tag: tag};
      r.tv = (s != 0); r.sel = s; r.off = o; r.wr = wr; r.sz = sz;
      r.wd = (sz == 0) ? (wd & 32'hff) : (sz == 1) ? (wd & 32'hffff) : wd;
      full = {4'hC, s, 2'b00, o};
      if (s == 0) flt = 1;
      else if (!wr) begin
        if (peri) acc = (sz == 0) ? (full & 32'hff) : (sz == 1) ? (full & 32'hffff) : full;
        else if (sz == 0) acc = a[0] ? {24'd0, o[7:0]} : {24'd0, o[15:8]};
        else acc = {16'd0, o[15:0]};
      end
      beats.push_back(r);
    end
    resp = '{default: 0, tag: tag};
    resp.rdy = 1; resp.rd = acc; resp.flt = flt;
    @(posedge clk); #2;
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    exp_q.push_back(idle);
    foreach (beats[i]) exp_q.push_back(beats[i]);
    exp_q.push_back(resp);
    repeat (beats.size() + 1) @(posedge clk);
    #2 req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    bit bad;
    if (exp_q.size() > 0) cur = exp_q.pop_front();
    else cur = '{default: 0, tag: (rst_n ? "R11" : "R1")};
    bad = 0;
    n_cmp++;
    if (tgt_valid !== cur.tv) begin
      bad = 1;
      $display("FAIL %s tgt_valid act %0b exp %0b", cur.tag, tgt_valid, cur.tv);
    end else if (cur.tv) begin
      if ({tgt_sel, tgt_offset, tgt_write, tgt_size} !== {cur.sel, cur.off, cur.wr, cur.sz}) begin
        bad = 1;
        $display("FAIL %s beat sel/off/wr/sz act %0d/%h/%0b/%0d exp %0d/%h/%0b/%0d", cur.tag,
                 tgt_sel, tgt_offset, tgt_write, tgt_size, cur.sel, cur.off, cur.wr, cur.sz);
      end
      if (cur.wr && tgt_wdata !== cur.wd) begin
        bad = 1;
        $display("FAIL %s tgt_wdata act %h exp %h", cur.tag, tgt_wdata, cur.wd);
      end
    end
    if ({cpu_ready, cpu_rdata, cpu_fault} !== {cur.rdy, cur.rd, cur.flt}) begin
      bad = 1;
      $display("FAIL %s rdy/rdata/fault act %0b/%h/%0b exp %0b/%h/%0b", cur.tag,
               cpu_ready, cpu_rdata, cpu_fault, cur.rdy, cur.rd, cur.flt);
    end
    if (bad) n_bad++;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R3 register decodes, incl. A29 mirror and odd byte lane
    access(32'h0000_4004, 2'd1, 0, 0, "R3");
    access(32'h2000_4105, 2'd0, 0, 0, "R3");
    access(32'h0000_4010, 2'd1, 1, 32'h0000_BEEF, "R3");
    // R4 palette windows
    access(32'h0000_4210, 2'd1, 0, 0, "R4");
    access(32'h0000_4310, 2'd1, 0, 0, "R4");
    access(32'h0000_4310, 2'd1, 1, 32'h0000_1234, "R4");
    access(32'h0000_4200, 2'd0, 0, 0, "R4");
    // R5 boot ROM per CPU and edges
    access(32'h0000_0100, 2'd1, 0, 0, "R5");
    access(32'h0000_0100, 2'd1, 1, 32'h0000_5555, "R5");
    access(32'h0000_0800, 2'd1, 0, 0, "R5");
    access(32'h2000_0100, 2'd1, 0, 0, "R5");
    // R6 cartridge, frame buffer, SDRAM masks
    access(32'h0212_3456, 2'd1, 0, 0, "R6");
    access(32'h0212_3456, 2'd1, 1, 32'h0000_7777, "R6");
    access(32'h2402_4682, 2'd1, 0, 0, "R6");
    access(32'h0403_0001, 2'd0, 1, 32'h0000_00AB, "R6");
    access(32'h0607_FFFE, 2'd1, 0, 0, "R6");
    // R9 byte lanes
    access(32'h0200_1234, 2'd0, 0, 0, "R9");
    access(32'h0200_1235, 2'd0, 0, 0, "R9");
    // R7 data array and peripheral space
    access(32'hC000_0ABC, 2'd1, 0, 0, "R7");
    access(32'hFFFF_FE10, 2'd2, 0, 0, "R7");
    access(32'hFFFF_FE11, 2'd0, 0, 0, "R7");
    access(32'hFFFF_FE20, 2'd2, 1, 32'hCAFE_F00D, "R7");
    // R8 word splits
    access(32'h0600_1000, 2'd2, 0, 0, "R8");
    access(32'h2600_0010, 2'd2, 1, 32'hA1B2_C3D4, "R8");
    access(32'h0000_4020, 2'd2, 0, 0, "R8");
    // R10 unmapped slots
    access(32'h4000_0000, 2'd2, 0, 0, "R10");
    access(32'h8000_0040, 2'd1, 1, 32'h0000_9999, "R10");
    // R2 mirrors and a spare slot
    access(32'h2200_0002, 2'd1, 0, 0, "R2");
    access(32'hC200_0000, 2'd1, 0, 0, "R2");
    // switch CPU identity
    cpu_id = 1'b1;
    access(32'h0000_0100, 2'd1, 0, 0, "R5");
    access(32'hC000_0ABC, 2'd1, 0, 0, "R7");
    access(32'hC000_0ABE, 2'd1, 1, 32'h0000_4321, "R7");
    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired act running exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule